// File: doc/BRIEF.md
# Pack Overcurrent and Short-Circuit Trip Controller

This block supervises the current of a two-cell lithium pack. It receives a stream of signed sense-resistor voltage samples in microvolts. A positive sample means charge current and a negative sample means discharge current. Three detectors run side by side on that stream:

- discharge overcurrent (OCD)
- discharge short circuit (SCD)
- charge short circuit (SCC)

Each detector has its own threshold code and its own delay code, and each scales its codes with its own step sizes. A detector trips once its condition has lasted for the programmed delay, measured in microsecond ticks. The trip is then latched. A discharge trip removes the discharge FET enable, and a charge trip removes the charge FET enable. A host clear releases every latched trip.

Each detector is a small state machine with three states. **DET_IDLE** waits for a qualifying sample. **DET_TIMING** counts ticks while the condition persists. **DET_LATCHED** holds the trip. The transitions are:

| Transition | From → To | Cause |
|---|---|---|
| *arm* | DET_IDLE → DET_TIMING | a qualifying sample arrives and the delay is non-zero |
| *instant trip* | DET_IDLE → DET_LATCHED | a qualifying sample arrives and the delay is zero |
| *abort* | DET_TIMING → DET_IDLE | a non-qualifying sample arrives |
| *expire* | DET_TIMING → DET_LATCHED | the tick count reaches the delay |
| *release* | any state → DET_IDLE | host clear |

Top module: `ocsc_guard`

## Requirements
- R1: After reset, `chg_en` and `dsg_en` are 1 and all three fault flags are 0.
- R2: OCD qualifies on a sample when -sample >= 50000 + 10000*min(code,15) µV. The OCD threshold code is 5 bits wide, so codes 16 to 31 act as code 15 (200 mV).
- R3: SCD qualifies on a sample when -sample >= 100000 + 50000*min(code,7) µV. Codes above 7 act as 7 (450 mV).
- R4: SCC qualifies on a sample when +sample >= 100000 + 50000*min(code,4) µV. Codes above 4 act as 4 (300 mV).
- R5: The OCD delay is 1000 + 2000*code ticks, with a 4-bit code. After the arming sample, the flag is still 0 after delay-1 ticks and is 1 after delay ticks.
- R6: The SCD delay is 122*code ticks and the SCC delay is 61*code ticks, each with a 4-bit code. With code 0, the flag is set at the same clock edge that takes the qualifying sample.
- R7: A non-qualifying sample during timing returns the detector to idle. The next qualifying sample restarts the full delay from zero.
- R8: A latched flag stays 1 through later samples and ticks until `host_clr` is 1. The cycle after `host_clr` is 1, all flags are 0.
- R9: `dsg_en` is 0 exactly while OCD or SCD is latched, and `chg_en` is 0 exactly while SCC is latched. A fault of one kind never changes the other enable.
- R10: Positive samples never qualify for OCD or SCD. Negative samples never qualify for SCC.
- R11: `smp_uv` is evaluated only in cycles where `smp_vld` is 1. Changes of `smp_uv` in other cycles have no effect.
- R12: Ticks that arrive while a detector is idle are not counted toward its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_uv | input | 20 | Signed sense voltage in µV |
| tick_us | input | 1 | One-microsecond timing tick |
| ocd_thr_code | input | 5 | Discharge overcurrent threshold code |
| ocd_dly_code | input | 4 | Discharge overcurrent delay code |
| scd_thr_code | input | 5 | Discharge short-circuit threshold code |
| scd_dly_code | input | 4 | Discharge short-circuit delay code |
| scc_thr_code | input | 5 | Charge short-circuit threshold code |
| scc_dly_code | input | 4 | Charge short-circuit delay code |
| host_clr | input | 1 | Releases all latched faults |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |
| ocd_flag | output | 1 | Discharge overcurrent latched |
| scd_flag | output | 1 | Discharge short circuit latched |
| scc_flag | output | 1 | Charge short circuit latched |

## Verification
The assertions check on every cycle that a latched flag holds until a clear, and that a clear empties every flag one cycle later. They also check that the discharge enable only falls together with a discharge fault. Finally, they check that an overcurrent trip only ever follows a tick, and that a short-circuit trip only follows a sample or a tick. The exact threshold edges, the saturation of out-of-range codes, and the tick counts of every delay code can only be shown by the bench sweeps. The same holds for the restart after an abort, the sign selectivity, and the ignored unstrobed samples.

// File: rtl/ocsc_pkg.sv
package ocsc_pkg;

    typedef enum logic [1:0] {
        DET_IDLE    = 2'd0,
        DET_TIMING  = 2'd1,
        DET_LATCHED = 2'd2
    } det_state_e;

    localparam int NUM_DET = 3;
    localparam int DET_OCD = 0;
    localparam int DET_SCD = 1;
    localparam int DET_SCC = 2;

    // threshold floor in microvolts, per detector
    function automatic int thr_base_uv(input int k);
        case (k)
            DET_OCD: return 50000;
            default: return 100000;
        endcase
    endfunction

    function automatic int thr_step_uv(input int k);
        case (k)
            DET_OCD: return 10000;
            default: return 50000;
        endcase
    endfunction

    // highest legal threshold code; larger codes saturate here
    function automatic int thr_max_code(input int k);
        case (k)
            DET_OCD: return 15;
            DET_SCD: return 7;
            default: return 4;
        endcase
    endfunction

    function automatic int dly_base_us(input int k);
        case (k)
            DET_OCD: return 1000;
            default: return 0;
        endcase
    endfunction

    function automatic int dly_step_us(input int k);
        case (k)
            DET_OCD: return 2000;
            DET_SCD: return 122;
            default: return 61;
        endcase
    endfunction

    // 1: detector looks at discharge (negative) samples
    function automatic bit det_is_dischg(input int k);
        return (k != DET_SCC);
    endfunction

endpackage

// File: rtl/ocsc_thresh.sv
module ocsc_thresh #(
    parameter int SMP_W    = 20,
    parameter int CODE_W   = 5,
    parameter int BASE_UV  = 50000,
    parameter int STEP_UV  = 10000,
    parameter int MAX_CODE = 15,
    parameter bit DISCHG   = 1'b1
) (
    input  logic signed [SMP_W-1:0]  smp_uv,
    input  logic        [CODE_W-1:0] code,
    output logic                     over
);
    localparam int MAG_W = SMP_W + 1;

    logic        [CODE_W-1:0] sat_code;
    logic        [MAG_W-1:0]  thr_u;
    logic signed [MAG_W-1:0]  smp_ext;
    logic signed [MAG_W-1:0]  mag;

    always_comb begin
        if (code > CODE_W'(MAX_CODE)) begin
            sat_code = CODE_W'(MAX_CODE);
        end else begin
            sat_code = code;
        end
        thr_u = MAG_W'(BASE_UV) + MAG_W'(STEP_UV) * MAG_W'(sat_code);
    end

    assign smp_ext = MAG_W'(smp_uv);

    generate
        if (DISCHG) begin : g_neg
            assign mag = -smp_ext;
        end else begin : g_pos
            assign mag = smp_ext;
        end
    endgenerate

    assign over = (mag >= $signed(thr_u));

endmodule

// File: rtl/ocsc_timer.sv
module ocsc_timer
    import ocsc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DLY_CODE_W  = 4,
    parameter int DLY_BASE_US = 1000,
    parameter int DLY_STEP_US = 2000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic                  over,
    input  logic                  tick,
    input  logic                  clr,
    input  logic [DLY_CODE_W-1:0] dly_code,
    output logic                  latched
);
    det_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] dly_lim;
    logic [CNT_W-1:0] cnt_inc;

    assign dly_lim = CNT_W'(DLY_BASE_US) + CNT_W'(DLY_STEP_US) * CNT_W'(dly_code);
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DET_IDLE: begin
                if (smp_vld && over) begin
                    if (dly_lim == '0) begin
                        st_d = DET_LATCHED;          // instant trip
                    end else begin
                        st_d  = DET_TIMING;          // arm
                        cnt_d = '0;
                    end
                end
            end
            DET_TIMING: begin
                if (smp_vld && !over) begin
                    st_d  = DET_IDLE;                // abort
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_inc >= dly_lim) begin
                        st_d  = DET_LATCHED;         // expire
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            DET_LATCHED: begin
                st_d = DET_LATCHED;
            end
            default: begin
                st_d  = DET_IDLE;
                cnt_d = '0;
            end
        endcase
        if (clr) begin
            st_d  = DET_IDLE;                        // release
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DET_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        latched = (st_q == DET_LATCHED);
    end

endmodule

// File: rtl/ocsc_detector.sv
module ocsc_detector
    import ocsc_pkg::*;
#(
    parameter int SMP_W      = 20,
    parameter int THR_CODE_W = 5,
    parameter int DLY_CODE_W = 4,
    parameter int CNT_W      = 16,
    parameter int KIND       = DET_OCD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_uv,
    input  logic                    tick,
    input  logic                    clr,
    input  logic [THR_CODE_W-1:0]   thr_code,
    input  logic [DLY_CODE_W-1:0]   dly_code,
    output logic                    latched
);
    logic over;

    ocsc_thresh #(
        .SMP_W   (SMP_W),
        .CODE_W  (THR_CODE_W),
        .BASE_UV (thr_base_uv(KIND)),
        .STEP_UV (thr_step_uv(KIND)),
        .MAX_CODE(thr_max_code(KIND)),
        .DISCHG  (det_is_dischg(KIND))
    ) u_thr (
        .smp_uv(smp_uv),
        .code  (thr_code),
        .over  (over)
    );

    ocsc_timer #(
        .CNT_W      (CNT_W),
        .DLY_CODE_W (DLY_CODE_W),
        .DLY_BASE_US(dly_base_us(KIND)),
        .DLY_STEP_US(dly_step_us(KIND))
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .over    (over),
        .tick    (tick),
        .clr     (clr),
        .dly_code(dly_code),
        .latched (latched)
    );

endmodule

// File: rtl/ocsc_guard.sv
module ocsc_guard
    import ocsc_pkg::*;
#(
    parameter int SMP_W      = 20,
    parameter int THR_CODE_W = 5,
    parameter int DLY_CODE_W = 4,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_uv,
    input  logic                    tick_us,
    input  logic [THR_CODE_W-1:0]   ocd_thr_code,
    input  logic [DLY_CODE_W-1:0]   ocd_dly_code,
    input  logic [THR_CODE_W-1:0]   scd_thr_code,
    input  logic [DLY_CODE_W-1:0]   scd_dly_code,
    input  logic [THR_CODE_W-1:0]   scc_thr_code,
    input  logic [DLY_CODE_W-1:0]   scc_dly_code,
    input  logic                    host_clr,
    output logic                    chg_en,
    output logic                    dsg_en,
    output logic                    ocd_flag,
    output logic                    scd_flag,
    output logic                    scc_flag
);
    logic [THR_CODE_W-1:0] thr_code [NUM_DET];
    logic [DLY_CODE_W-1:0] dly_code [NUM_DET];
    logic [NUM_DET-1:0]    flt;

    assign thr_code[DET_OCD] = ocd_thr_code;
    assign thr_code[DET_SCD] = scd_thr_code;
    assign thr_code[DET_SCC] = scc_thr_code;
    assign dly_code[DET_OCD] = ocd_dly_code;
    assign dly_code[DET_SCD] = scd_dly_code;
    assign dly_code[DET_SCC] = scc_dly_code;

    generate
        for (genvar gi = 0; gi < NUM_DET; gi++) begin : g_det
            ocsc_detector #(
                .SMP_W     (SMP_W),
                .THR_CODE_W(THR_CODE_W),
                .DLY_CODE_W(DLY_CODE_W),
                .CNT_W     (CNT_W),
                .KIND      (gi)
            ) u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .smp_vld (smp_vld),
                .smp_uv  (smp_uv),
                .tick    (tick_us),
                .clr     (host_clr),
                .thr_code(thr_code[gi]),
                .dly_code(dly_code[gi]),
                .latched (flt[gi])
            );
        end
    endgenerate

    always_comb begin
        ocd_flag = flt[DET_OCD];
        scd_flag = flt[DET_SCD];
        scc_flag = flt[DET_SCC];
        dsg_en   = !(flt[DET_OCD] || flt[DET_SCD]);
        chg_en   = !flt[DET_SCC];
    end

endmodule

// File: rtl/ocsc_guard_chk.sv
module ocsc_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_vld,
    input logic tick_us,
    input logic host_clr,
    input logic chg_en,
    input logic dsg_en,
    input logic ocd_flag,
    input logic scd_flag,
    input logic scc_flag
);
    logic [2:0] flags;
    assign flags = {scc_flag, scd_flag, ocd_flag};

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clr |=> (($past(flags) & flags) == $past(flags)));

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (flags == 3'b000));

    // R9
    dsg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en) |-> (ocd_flag || scd_flag));

    // R9
    chg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_en) |-> $rose(scc_flag));

    // R5
    ocd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocd_flag) |-> $past(tick_us));

    // R6
    scd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scd_flag) |-> $past(smp_vld || tick_us));

endmodule

bind ocsc_guard ocsc_guard_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .tick_us (tick_us),
    .host_clr(host_clr),
    .chg_en  (chg_en),
    .dsg_en  (dsg_en),
    .ocd_flag(ocd_flag),
    .scd_flag(scd_flag),
    .scc_flag(scc_flag)
);

// File: tb/ocsc_guard_bench.sv
module ocsc_guard_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [19:0] smp_uv = '0;
    logic               tick_us = 1'b0;
    logic [4:0]         ocd_thr_code = '0;
    logic [3:0]         ocd_dly_code = '0;
    logic [4:0]         scd_thr_code = '0;
    logic [3:0]         scd_dly_code = '0;
    logic [4:0]         scc_thr_code = '0;
    logic [3:0]         scc_dly_code = '0;
    logic               host_clr = 1'b0;
    logic               chg_en, dsg_en, ocd_flag, scd_flag, scc_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ocsc_guard u_ocsc_guard (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_uv(smp_uv),
        .tick_us(tick_us),
        .ocd_thr_code(ocd_thr_code), .ocd_dly_code(ocd_dly_code),
        .scd_thr_code(scd_thr_code), .scd_dly_code(scd_dly_code),
        .scc_thr_code(scc_thr_code), .scc_dly_code(scc_dly_code),
        .host_clr(host_clr), .chg_en(chg_en), .dsg_en(dsg_en),
        .ocd_flag(ocd_flag), .scd_flag(scd_flag), .scc_flag(scc_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int flag_of(input int k);
        case (k)
            0: return int'(ocd_flag);
            1: return int'(scd_flag);
            default: return int'(scc_flag);
        endcase
    endfunction

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic clear_all();
        @(negedge clk);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    task automatic put_sample(input int v);
        smp_uv  = 20'(v);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_us = 1'b1;
        repeat (n) @(negedge clk);
        tick_us = 1'b0;
    endtask

    task automatic delay_case(input string req, input int k, input int n, input int v);
        clear_all();
        put_sample(v);
        if (n > 0) begin
            run_ticks(n - 1);
            chk(req, flag_of(k), 0);
            run_ticks(1);
        end
        chk(req, flag_of(k), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chg_en", int'(chg_en), 1);
        chk("R1 dsg_en", int'(dsg_en), 1);
        chk("R1 flags", int'({ocd_flag, scd_flag, scc_flag}), 0);

        // R3 SCD threshold sweep with saturation, delay code 0
        ocd_thr_code = 5'd31;
        ocd_dly_code = 4'd15;
        scd_dly_code = 4'd0;
        for (int c = 0; c < 32; c++) begin
            int thr;
            thr = 100000 + 50000 * min_i(c, 7);
            scd_thr_code = 5'(c);
            clear_all();
            put_sample(-(thr - 1));
            chk("R3 below", int'(scd_flag), 0);
            put_sample(-thr);
            chk("R3 at", int'(scd_flag), 1);
            chk("R9 scd keeps chg_en", int'(chg_en), 1);
            chk("R9 scd drops dsg_en", int'(dsg_en), 0);
        end

        // R4 SCC threshold sweep with saturation, delay code 0
        scc_dly_code = 4'd0;
        for (int c = 0; c < 32; c++) begin
            int thr;
            thr = 100000 + 50000 * min_i(c, 4);
            scc_thr_code = 5'(c);
            clear_all();
            put_sample(thr - 1);
            chk("R4 below", int'(scc_flag), 0);
            put_sample(thr);
            chk("R4 at", int'(scc_flag), 1);
            chk("R9 scc drops chg_en", int'(chg_en), 0);
            chk("R9 scc keeps dsg_en", int'(dsg_en), 1);
        end

        // R2 OCD threshold sweep with saturation, delay 1000 ticks
        scd_thr_code = 5'd31;
        ocd_dly_code = 4'd0;
        for (int c = 0; c < 32; c++) begin
            int thr;
            thr = 50000 + 10000 * min_i(c, 15);
            ocd_thr_code = 5'(c);
            clear_all();
            put_sample(-(thr - 1));
            run_ticks(1000);
            chk("R2 below", int'(ocd_flag), 0);
            clear_all();
            put_sample(-thr);
            run_ticks(1000);
            chk("R2 at", int'(ocd_flag), 1);
        end

        // R5 OCD delay for selected codes
        ocd_thr_code = 5'd0;
        for (int i = 0; i < 3; i++) begin
            int c;
            c = (i == 0) ? 0 : ((i == 1) ? 1 : 15);
            ocd_dly_code = 4'(c);
            delay_case("R5 ocd delay", 0, 1000 + 2000 * c, -60000);
        end

        // R6 SCD and SCC delay sweeps over every code
        scd_thr_code = 5'd0;
        ocd_thr_code = 5'd31;
        for (int c = 0; c < 16; c++) begin
            scd_dly_code = 4'(c);
            delay_case("R6 scd delay", 1, 122 * c, -150000);
        end
        scc_thr_code = 5'd0;
        for (int c = 0; c < 16; c++) begin
            scc_dly_code = 4'(c);
            delay_case("R6 scc delay", 2, 61 * c, 150000);
        end

        // R7 abort then full restart
        scd_dly_code = 4'd10;
        clear_all();
        put_sample(-150000);
        run_ticks(1000);
        put_sample(-50000);
        chk("R7 abort", int'(scd_flag), 0);
        put_sample(-150000);
        run_ticks(1219);
        chk("R7 restart not early", int'(scd_flag), 0);
        run_ticks(1);
        chk("R7 restart expires", int'(scd_flag), 1);

        // R8 hold through samples and ticks, then clear
        put_sample(0);
        run_ticks(3000);
        put_sample(200000);
        chk("R8 hold", int'(scd_flag), 1);
        clear_all();
        chk("R8 clear", int'({ocd_flag, scd_flag, scc_flag}), 0);
        chk("R8 enables back", int'({chg_en, dsg_en}), 3);

        // R10 polarity selectivity
        scd_dly_code = 4'd0;
        scc_dly_code = 4'd0;
        ocd_thr_code = 5'd0;
        ocd_dly_code = 4'd0;
        clear_all();
        put_sample(500000);
        run_ticks(1000);
        chk("R10 positive no ocd", int'(ocd_flag), 0);
        chk("R10 positive no scd", int'(scd_flag), 0);
        clear_all();
        put_sample(-500000);
        chk("R10 negative no scc", int'(scc_flag), 0);

        // R11 unstrobed samples ignored
        clear_all();
        put_sample(0);
        smp_uv = -20'sd500000;
        repeat (5) @(negedge clk);
        chk("R11 no strobe scd", int'(scd_flag), 0);
        smp_uv = 20'sd500000;
        repeat (5) @(negedge clk);
        chk("R11 no strobe scc", int'(scc_flag), 0);

        // R12 idle ticks not counted
        scd_dly_code = 4'd5;
        clear_all();
        run_ticks(2000);
        put_sample(-150000);
        run_ticks(609);
        chk("R12 idle ticks ignored", int'(scd_flag), 0);
        run_ticks(1);
        chk("R12 expiry", int'(scd_flag), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule